// File: doc/BRIEF.md
# Dual-Register DDS Waveform Core

This block is a direct digital synthesis engine. Two 28-bit frequency tuning words and two 12-bit phase offsets are held on chip together with a control word, and every one of them is loaded through a single 16-bit write port. On each clock the chosen tuning word is added into a 28-bit phase accumulator. The chosen offset is then added to the top 12 bits of the accumulator, and that sum drives the output shaper.

The shaper turns the phase sum into a 10-bit DAC code: a sine value computed by a function or a folded triangle. It also produces a one-bit square signal taken from the phase MSB, either at full rate or halved. Control bits stop the accumulator, blank the DAC code and clear the datapath, so software can retune or park the generator without glitches.

The write port uses valid/ready. Ready is held high, so a word is taken in every cycle in which valid is high and no back-pressure is ever applied. A write takes effect at the clock edge that accepts it.

Top module: `dds_core`

## Requirements
- R1: A word accepted on the write port (wr_valid=1, wr_ready=1, and wr_ready is always 1) is routed by bits 15:14: 00 loads the control word, 01 loads tuning word 0, 10 loads tuning word 1, and 11 loads a phase offset. For a phase write, bit 13 picks offset 1 (1) or offset 0 (0) and bits 11:0 carry the value.
- R2: Control bit 13 set means each tuning write carries 14 bits. The first write to a register is the low half, and the second is the high half. The 28-bit value changes only when the high half arrives. Any control write restarts this pairing at the low half.
- R3: Control bit 13 clear means a tuning write replaces one 14-bit half and leaves the other unchanged. Control bit 12 picks the half: 1 for the high half, 0 for the low half.
- R4: Control bit 11 selects the tuning word that feeds the accumulator: 0 for word 0, 1 for word 1.
- R5: Control bit 10 selects the phase offset added to the accumulator's top 12 bits: 0 for offset 0, 1 for offset 1.
- R6: With control bit 1 clear, the DAC code is computed from the 12-bit phase sum a as follows. Let h = a[10:0] and m = (h*(2048-h)) >> 11. The code is min(512+m, 1023) when a[11]=0, and 512-m when a[11]=1.
- R7: With control bit 1 set, the DAC code is a[10:1] when a[11]=0 and the bitwise inverse of a[10:1] when a[11]=1.
- R8: Control bit 8 set clears the accumulator, the DAC code, the square output and the divider from the next edge on. Writing control with bit 8 clear lets the datapath run again.
- R9: Control bit 7 set freezes the accumulator, and both outputs hold their present values.
- R10: Control bit 6 set drives the DAC code to 0, while the square output keeps working.
- R11: Control bit 5 set enables the square output. With bit 3 set, the square output follows the phase-sum MSB. With bit 3 clear, it toggles on each rising edge of that MSB. With bit 5 clear, the square output is 0.
- R12: Control bits 5 and 1 both set is a reserved combination, and it forces the DAC code to 0.
- R13: After rst_n goes low, all registers are zero, so dac_code=0, msb_out=0 and wr_ready=1. The outputs are registered and change one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word accepted (always high) |
| wr_data | input | 16 | Write word: destination in bits 15:14, payload below |
| dac_code | output | 10 | Registered DAC code, offset binary |
| msb_out | output | 1 | Registered square / MSB output |

## Verification
The hardest state to reach is a paired tuning load that is only half done. It has to be shown that the first word does nothing at all: neither an immediate low-half update nor a high-half update. The bench starts the accumulator running on word 0 with pairing enabled. It then writes a first word that would produce visible motion if it were mistaken for a high half, and checks that the triangle code stays flat. Only after the full pair has been written does it expect the code to climb by one per clock. Sleep, blanking and the reserved combination are reached by parking the accumulator at zero and walking a table of phase offsets, so each output value depends on a single known phase.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    DST_CTRL  = 2'b00,
    DST_FREQ0 = 2'b01,
    DST_FREQ1 = 2'b10,
    DST_PHASE = 2'b11
  } dst_e;

  typedef struct packed {
    logic pair28;
    logic hi_half;
    logic fsel;
    logic psel;
    logic clr;
    logic sleep_acc;
    logic sleep_dac;
    logic bit_en;
    logic bit_full;
    logic tri_mode;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [15:0] w);
    ctrl_t c;
    c.pair28    = w[13];
    c.hi_half   = w[12];
    c.fsel      = w[11];
    c.psel      = w[10];
    c.clr       = w[8];
    c.sleep_acc = w[7];
    c.sleep_dac = w[6];
    c.bit_en    = w[5];
    c.bit_full  = w[3];
    c.tri_mode  = w[1];
    return c;
  endfunction
endpackage

// File: rtl/dds_regs.sv
module dds_regs
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output ctrl_t            ctrl,
  output logic [ACC_W-1:0] freq_sel,
  output logic [PH_W-1:0]  phase_sel
);
  localparam int HALF = ACC_W / 2;

  dst_e dst;
  logic ctrl_wr;
  assign dst     = dst_e'(wr_data[15:14]);
  assign ctrl_wr = wr_en && (dst == DST_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= decode_ctrl(wr_data);
  end

  for (genvar i = 0; i < 2; i++) begin : g_freq
    logic [ACC_W-1:0] val;
    logic [HALF-1:0]  low_hold;
    logic             want_high;
    logic             hit;
    assign hit = wr_en && (dst == ((i == 0) ? DST_FREQ0 : DST_FREQ1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val       <= '0;
        low_hold  <= '0;
        want_high <= 1'b0;
      end else if (ctrl_wr) begin
        want_high <= 1'b0;
      end else if (hit) begin
        if (ctrl.pair28) begin
          if (!want_high) begin
            low_hold  <= wr_data[HALF-1:0];
            want_high <= 1'b1;
          end else begin
            val       <= {wr_data[HALF-1:0], low_hold};
            want_high <= 1'b0;
          end
        end else if (ctrl.hi_half) begin
          val[ACC_W-1:HALF] <= wr_data[HALF-1:0];
        end else begin
          val[HALF-1:0] <= wr_data[HALF-1:0];
        end
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_phase
    logic [PH_W-1:0] val;
    logic            hit;
    assign hit = wr_en && (dst == DST_PHASE) && (wr_data[13] == (j == 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= '0;
      else if (hit) val <= wr_data[PH_W-1:0];
    end
  end

  assign freq_sel  = ctrl.fsel ? g_freq[1].val : g_freq[0].val;
  assign phase_sel = ctrl.psel ? g_phase[1].val : g_phase[0].val;
endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [ACC_W-1:0] freq,
  input  logic [PH_W-1:0]  phase,
  output logic [PH_W-1:0]  psum
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (!hold) acc_q <= acc_q + freq;
  end

  assign psum = acc_q[ACC_W-1 -: PH_W] + phase;
endmodule

// File: rtl/dds_shaper.sv
module dds_shaper #(
  parameter int PH_W  = 12,
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             tri_mode,
  input  logic             sleep_dac,
  input  logic             bit_en,
  input  logic             bit_full,
  input  logic [PH_W-1:0]  psum,
  output logic [DAC_W-1:0] dac_code,
  output logic             msb_out
);
  localparam logic [PH_W-1:0]  HALFN = PH_W'(1) << (PH_W - 1);
  localparam int               SHIFT = 2 * PH_W - 4 - (DAC_W - 1);
  localparam logic [DAC_W:0]   MID   = (DAC_W + 1)'(1) << (DAC_W - 1);
  localparam logic [DAC_W-1:0] MAXC  = '1;

  function automatic logic [DAC_W-1:0] sine_code(input logic [PH_W-1:0] a);
    logic [PH_W-1:0]   h;
    logic [PH_W-1:0]   rem;
    logic [2*PH_W-1:0] p;
    logic [DAC_W:0]    mag;
    logic [DAC_W:0]    sum;
    h   = {1'b0, a[PH_W-2:0]};
    rem = HALFN - h;
    p   = h * rem;
    mag = p[SHIFT +: DAC_W + 1];
    if (a[PH_W-1]) begin
      sum = MID - mag;
      return sum[DAC_W-1:0];
    end
    sum = MID + mag;
    return sum[DAC_W] ? MAXC : sum[DAC_W-1:0];
  endfunction

  function automatic logic [DAC_W-1:0] tri_code(input logic [PH_W-1:0] a);
    logic [DAC_W-1:0] t;
    t = a[PH_W-2 -: DAC_W];
    return a[PH_W-1] ? ~t : t;
  endfunction

  logic             msb, msb_prev, half_q, half_next;
  logic [DAC_W-1:0] dac_next;

  assign msb       = psum[PH_W-1];
  assign half_next = half_q ^ (msb & ~msb_prev);

  always_comb begin
    if (sleep_dac || (bit_en && tri_mode)) dac_next = '0;
    else if (tri_mode)                     dac_next = tri_code(psum);
    else                                   dac_next = sine_code(psum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= '0;
      msb_out  <= 1'b0;
      msb_prev <= 1'b0;
      half_q   <= 1'b0;
    end else if (clr) begin
      dac_code <= '0;
      msb_out  <= 1'b0;
      msb_prev <= 1'b0;
      half_q   <= 1'b0;
    end else if (!hold) begin
      dac_code <= dac_next;
      msb_prev <= msb;
      half_q   <= half_next;
      msb_out  <= bit_en & (bit_full ? msb : half_next);
    end
  end
endmodule

// File: rtl/dds_core.sv
module dds_core
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [15:0]      wr_data,
  output logic [DAC_W-1:0] dac_code,
  output logic             msb_out
);
  ctrl_t            ctl;
  logic [ACC_W-1:0] freq_sel;
  logic [PH_W-1:0]  phase_sel;
  logic [PH_W-1:0]  psum;
  logic             wr_en;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid & wr_ready;

  dds_regs #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctl), .freq_sel(freq_sel), .phase_sel(phase_sel)
  );

  dds_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .hold(ctl.sleep_acc),
    .freq(freq_sel), .phase(phase_sel), .psum(psum)
  );

  dds_shaper #(.PH_W(PH_W), .DAC_W(DAC_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .hold(ctl.sleep_acc),
    .tri_mode(ctl.tri_mode), .sleep_dac(ctl.sleep_dac),
    .bit_en(ctl.bit_en), .bit_full(ctl.bit_full), .psum(psum),
    .dac_code(dac_code), .msb_out(msb_out)
  );
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk
  import dds_pkg::*;
#(
  parameter int DAC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input ctrl_t            ctl,
  input logic [DAC_W-1:0] dac_code,
  input logic             msb_out
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (dac_code == '0) && !msb_out); // R8

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sleep_acc && !ctl.clr) |=> ($stable(dac_code) && $stable(msb_out))); // R9

  AST_DAC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sleep_dac && !ctl.sleep_acc) |=> (dac_code == '0)); // R10

  AST_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.bit_en && !ctl.sleep_acc) |=> !msb_out); // R11

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.bit_en && ctl.tri_mode && !ctl.sleep_acc) |=> (dac_code == '0)); // R12
endmodule

bind dds_core dds_core_chk #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .dac_code(dac_code), .msb_out(msb_out)
);

// File: tb/dds_core_tb.sv
module dds_core_tb;
  localparam logic [15:0] B28 = 16'h2000, HLB = 16'h1000, FSL = 16'h0800, PSL = 16'h0400;
  localparam logic [15:0] RST = 16'h0100, SLP1 = 16'h0080, SLP12 = 16'h0040, OPB = 16'h0020;
  localparam logic [15:0] DV2 = 16'h0008, TRI = 16'h0002;

  typedef struct packed {
    logic [15:0] ctrl;
    logic        sel1;
    logic [11:0] ph;
    logic [9:0]  dac;
    logic        msb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h0000,      1'b0, 12'h000, 10'd512,  1'b0, 4'd6},   // R6 zero phase
    '{16'h0000,      1'b0, 12'h400, 10'd1023, 1'b0, 4'd6},   // R6 peak, clamped
    '{16'h0000,      1'b0, 12'h200, 10'd896,  1'b0, 4'd6},   // R6 rising slope
    '{16'h0000,      1'b0, 12'hC00, 10'd0,    1'b0, 4'd6},   // R6 trough
    '{16'h0000,      1'b0, 12'h800, 10'd512,  1'b0, 4'd6},   // R6 mid crossing
    '{TRI,           1'b0, 12'h7FE, 10'd1023, 1'b0, 4'd7},   // R7 top of ramp
    '{TRI,           1'b0, 12'h400, 10'd512,  1'b0, 4'd7},   // R7 mid ramp
    '{TRI,           1'b0, 12'hFFE, 10'd0,    1'b0, 4'd7},   // R7 folded bottom
    '{TRI,           1'b0, 12'h800, 10'd1023, 1'b0, 4'd7},   // R7 fold point
    '{OPB|DV2,       1'b0, 12'h800, 10'd512,  1'b1, 4'd11},  // R11 msb follows
    '{OPB|TRI|DV2,   1'b0, 12'h400, 10'd0,    1'b0, 4'd12},  // R12 reserved
    '{SLP12|OPB|DV2, 1'b0, 12'h800, 10'd0,    1'b1, 4'd10},  // R10 blank, msb alive
    '{PSL,           1'b1, 12'h400, 10'd1023, 1'b0, 4'd5},   // R5 offset 1, R1 bit 13
    '{16'h0000,      1'b1, 12'hC00, 10'd512,  1'b0, 4'd5}    // R5 offset 1 ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready;
  logic [9:0]  dac_code;
  logic        msb_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dds_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .dac_code(dac_code), .msb_out(msb_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic motion(input bit moving, input string req);
    int a;
    int b;
    wait_n(4);
    a = dac_code;
    wait_n(1);
    b = dac_code;
    check(b == (moving ? a + 1 : a), req, b, moving ? a + 1 : a);
  endtask

  task automatic edges(output int cnt);
    logic last;
    cnt = 0;
    wait_n(1);
    last = msb_out;
    for (int k = 0; k < 15; k++) begin
      wait_n(1);
      if (msb_out != last) cnt++;
      last = msb_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    wait_n(3);
    check(dac_code == 10'd0, "R13 dac after reset", dac_code, 0);
    check(msb_out == 1'b0, "R13 msb after reset", msb_out, 0);
    rst_n = 1'b1;
    check(wr_ready == 1'b1, "R1 ready high", wr_ready, 1);

    for (int i = 0; i < NV; i++) begin
      wr({2'b11, VECS[i].sel1, 1'b0, VECS[i].ph});
      wr(VECS[i].ctrl);
      wait_n(3);
      check(dac_code == VECS[i].dac, $sformatf("R%0d vector %0d dac", VECS[i].req, i),
            dac_code, VECS[i].dac);
      check(msb_out == VECS[i].msb, $sformatf("R%0d vector %0d msb", VECS[i].req, i),
            msb_out, VECS[i].msb);
    end

    wr(16'h0000 | PSL);
    wr(16'hC000);
    wr(16'hE000);
    wr(16'h0000 | RST | TRI);
    wr(16'h0000 | TRI);

    // R3 high half only, R4 word 1 selected
    wr(HLB);
    wr({2'b10, 14'd8});
    wr(TRI | RST);
    wr(TRI | FSL);
    motion(1'b1, "R4 word1 drives accumulator");
    wr(TRI | RST);
    wr(TRI);
    motion(1'b0, "R4 word0 (zero) selected");
    // R3 low half write keeps the high half
    wr(16'h0000);
    wr({2'b10, 14'd1});
    wr(TRI | RST);
    wr(TRI | FSL);
    motion(1'b1, "R3 high half retained");

    // R2 paired load on word 0
    wr(B28 | TRI | RST);
    wr(B28 | TRI);
    wr({2'b01, 14'd8});
    motion(1'b0, "R2 first half no effect");
    wr({2'b01, 14'd0});
    motion(1'b0, "R2 pair low=8 high=0");
    wr({2'b01, 14'd0});
    wr({2'b01, 14'd8});
    motion(1'b1, "R2 pair low=0 high=8");

    // R9 sleep freezes, release resumes
    wr(B28 | TRI | SLP1);
    motion(1'b0, "R9 sleep holds");
    wr(B28 | TRI);
    motion(1'b1, "R9 resume");

    // R8 control clear
    wr(TRI | RST);
    wait_n(3);
    check(dac_code == 10'd0, "R8 clear dac", dac_code, 0);
    motion(1'b0, "R8 clear holds zero");

    // R11 square output rates
    wr(HLB);
    wr({2'b01, 14'h1000});
    wr(OPB | DV2 | RST);
    wr(OPB | DV2);
    edges(cnt);
    check(cnt >= 7, "R11 full rate edges", cnt, 7);
    wr(OPB);
    edges(cnt);
    check(cnt >= 3 && cnt <= 4, "R11 halved edges", cnt, 4);
    wr(DV2);
    wait_n(3);
    check(msb_out == 1'b0, "R11 disabled msb", msb_out, 0);

    // R13 reset mid-run
    wr(TRI);
    wait_n(5);
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(1);
    check(dac_code == 10'd0, "R13 reset mid-run dac", dac_code, 0);
    check(msb_out == 1'b0, "R13 reset mid-run msb", msb_out, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule